// File: doc/BRIEF.md
# Phase Output Shaper with Pulse Deletion, Underlap and Trip

This block drives one leg of an inverter bridge. It takes a raw PWM level and produces the top-switch and bottom-switch drives. First, a qualification filter removes any high or low pulse that is shorter than a programmable minimum width. The filtered level then goes to a drive state machine. At every change of that level, the machine turns the conducting switch off and keeps both switches off for a programmable underlap. Only after the underlap does it turn on the opposite switch.

Two shutdown paths override the normal path:

- **Active-low reset.** While reset is low, both drives are held low. The reset also clears the filter, the drive state machine and the trip latch.
- **Emergency trip request.** This input blanks both drives in the same cycle through combinational gating. It also sets a trip latch on the next clock edge. Once set, the latch keeps both drives off until the next reset. The status output `trip_ok` goes low while the latch is set.

The minimum-width and underlap values are expected to stay constant outside reset.

Filter states are STEADY and QUALIFY:

- In STEADY, the raw level equals the filtered level. A raw level that differs either is accepted at once (when the minimum width is 0 or 1) or moves the filter to QUALIFY.
- In QUALIFY, the filter counts the consecutive cycles the raw level has differed. It returns to STEADY on one of two events. If the raw level returns to the filtered level, the pulse is deleted. If the count reaches the minimum width, the filtered level flips.

Drive states are GAP_LO, GAP_HI, DRV_LO, DRV_HI and TRIPPED. Their transitions are:

- A filtered rise moves DRV_LO or GAP_LO to GAP_HI, and the gap counter reloads.
- A filtered fall moves DRV_HI or GAP_HI to GAP_LO, and the gap counter reloads.
- An expired gap moves GAP_HI to DRV_HI, or GAP_LO to DRV_LO.
- A trip moves any state to TRIPPED, which is left only by reset.

Reset puts the machine in GAP_LO.

Top module: `phase_out_shaper`

## Requirements
- R1: `drv_top` and `drv_bot` are never high together.
- R2: One edge after the filtered level changes, the conducting switch turns off. Both drives then stay low for max(U,1) cycles before the opposite switch turns on, where U is `underlap`.
- R3: A raw level that differs from the filtered level for fewer than max(M,1) consecutive sampled edges is deleted, and the drives do not change. M is `min_width`.
- R4: A raw change held for max(M,1) consecutive edges is accepted. The conducting switch drops on the edge after that, so it drops max(M,1)+1 edges after the change.
- R5: If the filtered level reverses during an underlap gap, the gap restarts toward the new direction with a full max(U,1) cycles. The switch that was pending never turns on.
- R6: While `rst_n` is low, both drives are low and `trip_ok` is high. After release, `drv_bot` turns on after max(U,1) edges.
- R7: While `trip_req` is high, both drives are low in the same cycle, without waiting for a clock edge.
- R8: A `trip_req` seen at a clock edge latches the trip. From that edge, `trip_ok` reads 0 and both drives stay low until reset, whatever `trip_req` and `pwm_raw` do afterwards.
- R9: `min_width` values of 0 and 1 behave alike: a raw change is accepted on the first edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; inhibits both drives |
| pwm_raw | input | 1 | Unfiltered PWM level (1 = top switch wanted) |
| min_width | input | MIN_W | Minimum accepted pulse width in cycles |
| underlap | input | GAP_W | Both-off interval in cycles |
| trip_req | input | 1 | Emergency shutdown request, active high |
| drv_top | output | 1 | Top switch drive, active high |
| drv_bot | output | 1 | Bottom switch drive, active high |
| trip_ok | output | 1 | Low while the trip latch is set |

## Verification
The bench counts edges exactly around each filtered transition:

- It checks that the old switch survives through the qualification window and drops on the following edge.
- It checks that the new switch waits the full underlap. An off-by-one in the qualification count would show as a shifted drop edge. A missing gap would show as one switch rising on the edge the other falls.

Pulses one cycle shorter than the minimum width, in both polarities, are aimed at a filter that passes them. Such a filter would make a switch blink off. A reversal during the gap is aimed at a machine that does not reload its counter. That machine would either turn on the wrong switch or cut the new gap short.

The trip is exercised in three ways:

- It is released after latching, which exposes a level-sensitive trip that lets the drives resume.
- It is sampled within the same cycle, which exposes a registered-only trip.
- It is cleared by reset, which checks the latch comes out of trip.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

    typedef enum logic [2:0] {
        DS_GAP_LO  = 3'd0,
        DS_GAP_HI  = 3'd1,
        DS_DRV_LO  = 3'd2,
        DS_DRV_HI  = 3'd3,
        DS_TRIPPED = 3'd4
    } drv_state_t;

    typedef enum logic {
        FS_STEADY  = 1'b0,
        FS_QUALIFY = 1'b1
    } filt_state_t;

endpackage

// File: rtl/min_pulse_filter.sv
module min_pulse_filter
    import shaper_pkg::*;
#(
    parameter int MIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [MIN_W-1:0] min_width,
    output logic             filt
);

    localparam int EXT_W = MIN_W + 1;

    filt_state_t      st_q, st_d;
    logic [MIN_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;
    logic             differs;
    logic             qualified;

    assign differs   = (raw != filt_q);
    assign qualified = (EXT_W'(cnt_q) + EXT_W'(1)) >= EXT_W'(min_width);

    // next-state process
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        filt_d = filt_q;
        unique case (st_q)
            FS_STEADY: begin
                if (differs) begin
                    if (qualified) begin
                        filt_d = raw;
                        cnt_d  = '0;
                    end else begin
                        st_d  = FS_QUALIFY;
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            FS_QUALIFY: begin
                if (!differs) begin
                    st_d  = FS_STEADY;
                    cnt_d = '0;
                end else if (qualified) begin
                    st_d   = FS_STEADY;
                    filt_d = raw;
                    cnt_d  = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = FS_STEADY;
                cnt_d = '0;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FS_STEADY;
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    // output process
    always_comb begin
        filt = filt_q;
    end

    // R4
    filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(raw) == filt_q));

    // R3
    pulse_delete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_QUALIFY && !differs) |=> $stable(filt_q));

endmodule

// File: rtl/underlap_fsm.sv
module underlap_fsm
    import shaper_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filt,
    input  logic [GAP_W-1:0] underlap,
    input  logic             kill,
    output logic             want_top,
    output logic             want_bot
);

    localparam int EXT_W = GAP_W + 1;

    drv_state_t       st_q, st_d;
    logic [GAP_W-1:0] gc_q, gc_d;
    logic             gap_done;

    assign gap_done = (EXT_W'(gc_q) + EXT_W'(1)) >= EXT_W'(underlap);

    // next-state process
    always_comb begin
        st_d = st_q;
        gc_d = gc_q;
        if (kill) begin
            st_d = DS_TRIPPED;
            gc_d = '0;
        end else begin
            unique case (st_q)
                DS_GAP_LO: begin
                    if (filt) begin
                        st_d = DS_GAP_HI;
                        gc_d = '0;
                    end else if (gap_done) begin
                        st_d = DS_DRV_LO;
                        gc_d = '0;
                    end else begin
                        gc_d = gc_q + 1'b1;
                    end
                end
                DS_GAP_HI: begin
                    if (!filt) begin
                        st_d = DS_GAP_LO;
                        gc_d = '0;
                    end else if (gap_done) begin
                        st_d = DS_DRV_HI;
                        gc_d = '0;
                    end else begin
                        gc_d = gc_q + 1'b1;
                    end
                end
                DS_DRV_LO: begin
                    if (filt) begin
                        st_d = DS_GAP_HI;
                        gc_d = '0;
                    end
                end
                DS_DRV_HI: begin
                    if (!filt) begin
                        st_d = DS_GAP_LO;
                        gc_d = '0;
                    end
                end
                DS_TRIPPED: begin
                    st_d = DS_TRIPPED;
                end
                default: begin
                    st_d = DS_GAP_LO;
                    gc_d = '0;
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DS_GAP_LO;
            gc_q <= '0;
        end else begin
            st_q <= st_d;
            gc_q <= gc_d;
        end
    end

    // output process
    always_comb begin
        want_top = (st_q == DS_DRV_HI);
        want_bot = (st_q == DS_DRV_LO);
    end

    // R5
    gap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DS_GAP_HI && !filt && !kill) |=> (st_q == DS_GAP_LO && gc_q == '0));

    // R8
    tripped_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DS_TRIPPED) |=> (st_q == DS_TRIPPED));

endmodule

// File: rtl/trip_latch.sv
module trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_req,
    output logic tripped
);

    logic set_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= 1'b0;
        end else if (trip_req) begin
            set_q <= 1'b1;
        end
    end

    assign tripped = set_q;

    // R8
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_q |=> set_q);

endmodule

// File: rtl/phase_out_shaper.sv
module phase_out_shaper #(
    parameter int MIN_W = 8,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_raw,
    input  logic [MIN_W-1:0] min_width,
    input  logic [GAP_W-1:0] underlap,
    input  logic             trip_req,
    output logic             drv_top,
    output logic             drv_bot,
    output logic             trip_ok
);

    logic filt;
    logic tripped;
    logic want_top;
    logic want_bot;
    logic kill;

    min_pulse_filter #(.MIN_W(MIN_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (pwm_raw),
        .min_width (min_width),
        .filt      (filt)
    );

    trip_latch u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_req (trip_req),
        .tripped  (tripped)
    );

    assign kill = trip_req | tripped;

    underlap_fsm #(.GAP_W(GAP_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt     (filt),
        .underlap (underlap),
        .kill     (kill),
        .want_top (want_top),
        .want_bot (want_bot)
    );

    assign drv_top = want_top & ~trip_req;
    assign drv_bot = want_bot & ~trip_req;
    assign trip_ok = ~tripped;

    // R1
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_top && drv_bot));

    // R2
    top_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_top) |-> !$past(drv_bot));

    // R2
    bot_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_bot) |-> !$past(drv_top));

    // R7
    trip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_req |-> (!drv_top && !drv_bot));

    // R8
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_ok |-> (!drv_top && !drv_bot));

    // R6
    reset_hold_chk: assert property (@(posedge clk)
        !rst_n |-> (!drv_top && !drv_bot && trip_ok));

endmodule

// File: tb/tb_phase_out_shaper.sv
module tb_phase_out_shaper;

    localparam int MIN_W = 8;
    localparam int GAP_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pwm_raw;
    logic [MIN_W-1:0] min_width;
    logic [GAP_W-1:0] underlap;
    logic             trip_req;
    logic             drv_top;
    logic             drv_bot;
    logic             trip_ok;

    int checks = 0;
    int errors = 0;
    int mm;
    int gg;
    bit done = 0;

    always #4 clk = ~clk;

    phase_out_shaper #(.MIN_W(MIN_W), .GAP_W(GAP_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_raw   (pwm_raw),
        .min_width (min_width),
        .underlap  (underlap),
        .trip_req  (trip_req),
        .drv_top   (drv_top),
        .drv_bot   (drv_bot),
        .trip_ok   (trip_ok)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // expected vector is {drv_top, drv_bot, trip_ok}
    task automatic expect_out(string req, string what, logic [2:0] exp);
        checks++;
        if ({drv_top, drv_bot, trip_ok} !== exp) begin
            errors++;
            $display("FAIL %s %s: actual top/bot/ok=%b expected=%b",
                     req, what, {drv_top, drv_bot, trip_ok}, exp);
        end
    endtask

    task automatic expect_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset(int m, int u);
        @(negedge clk);
        rst_n     = 1'b0;
        pwm_raw   = 1'b0;
        trip_req  = 1'b0;
        min_width = MIN_W'(m);
        underlap  = GAP_W'(u);
        mm = (m < 1) ? 1 : m;
        gg = (u < 1) ? 1 : u;
        tick(2);
        expect_out("R6", "held in reset", 3'b001);
        rst_n = 1'b1;
        if (gg > 1) begin
            tick(gg - 1);
            expect_out("R6", "start-up gap", 3'b001);
            tick(1);
        end else begin
            tick(1);
        end
        expect_out("R6", "bottom on after start-up gap", 3'b011);
    endtask

    task automatic t_rise(string req);
        pwm_raw = 1'b1;
        tick(mm);
        expect_out(req, "rise: bottom kept through qualify", 3'b011);
        tick(1);
        expect_out("R2", "rise: gap starts", 3'b001);
        if (gg > 1) begin
            tick(gg - 1);
            expect_out("R2", "rise: gap end", 3'b001);
        end
        tick(1);
        expect_out("R2", "rise: top on", 3'b101);
    endtask

    task automatic t_fall(string req);
        pwm_raw = 1'b0;
        tick(mm);
        expect_out(req, "fall: top kept through qualify", 3'b101);
        tick(1);
        expect_out("R2", "fall: gap starts", 3'b001);
        if (gg > 1) begin
            tick(gg - 1);
            expect_out("R2", "fall: gap end", 3'b001);
        end
        tick(1);
        expect_out("R2", "fall: bottom on", 3'b011);
    endtask

    task automatic t_glitch(logic lvl);
        bit moved = 0;
        logic [2:0] hold = lvl ? 3'b011 : 3'b101;
        pwm_raw = lvl;
        tick(mm - 1);
        pwm_raw = ~lvl;
        for (int i = 0; i < mm + gg + 3; i++) begin
            tick(1);
            if ({drv_top, drv_bot, trip_ok} !== hold) moved = 1;
        end
        expect_bit("R3", lvl ? "high glitch deleted" : "low glitch deleted", moved, 1'b0);
    endtask

    task automatic t_exact();
        pwm_raw = 1'b1;
        tick(mm);
        pwm_raw = 1'b0;
        tick(1);
        expect_out("R4", "min-width pulse accepted", 3'b001);
        tick(mm + gg + 2);
        expect_out("R4", "back on bottom", 3'b011);
    endtask

    task automatic t_abort();
        bit top_seen = 0;
        pwm_raw = 1'b1;
        tick(2);
        expect_out("R5", "gap toward top", 3'b001);
        pwm_raw = 1'b0;
        for (int i = 0; i < gg + 1; i++) begin
            tick(1);
            if (drv_top) top_seen = 1;
        end
        expect_out("R5", "reloaded gap still running", 3'b001);
        tick(1);
        expect_out("R5", "bottom after reloaded gap", 3'b011);
        expect_bit("R5", "pending top never driven", top_seen, 1'b0);
    endtask

    task automatic t_trip();
        bit leak = 0;
        trip_req = 1'b1;
        #1;
        expect_out("R7", "same-cycle blank", 3'b001);
        tick(1);
        expect_out("R8", "trip latched", 3'b000);
        trip_req = 1'b0;
        for (int i = 0; i < 30; i++) begin
            pwm_raw = (i % 10) < 5;
            tick(1);
            if ({drv_top, drv_bot, trip_ok} !== 3'b000) leak = 1;
        end
        expect_bit("R8", "stays tripped after release", leak, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        pwm_raw = 1'b0;
        trip_req = 1'b0;
        min_width = '0;
        underlap = '0;

        do_reset(3, 4);
        t_rise("R4");
        t_fall("R4");
        t_glitch(1'b1);
        t_rise("R4");
        t_glitch(1'b0);
        t_fall("R4");
        t_exact();

        do_reset(0, 0);
        t_rise("R9");
        t_fall("R9");
        do_reset(1, 2);
        t_rise("R9");
        t_fall("R9");

        do_reset(1, 6);
        t_abort();

        do_reset(2, 3);
        t_rise("R4");
        t_trip();
        do_reset(2, 3);
        t_rise("R4");
        rst_n = 1'b0;
        #1;
        expect_out("R6", "reset mid-run blanks", 3'b001);
        tick(1);
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule